// File: doc/BRIEF.md
# Alarm-Triggered Power Enable Controller

This block drives the enable line of an external power-management device from real-time-clock events. Software arms power control by setting one bit in a 32-bit control register. Once armed, the second alarm of the clock turns the enable line off, provided that alarm's interrupt enable is set. The calendar counter and the alarm comparator sit outside this block; each alarm match reaches it as a single-cycle pulse.

Four asynchronous wakeup pins can bring the supply back. Each pin has its own enable bit and its own polarity bit, and the polarity defaults to active low. Each pin passes through a two-flop synchronizer and a polarity stage. Any enabled pin that is active raises a wake request. If a wake request arrives while the supply is off, the enable line returns to on and the arming bit is cleared.

Register access uses one write port with a 2-bit select. Select 0 is the control register, select 1 is the interrupt-enable register and select 2 is the status register. Each register has its own readback output.

Top module: `pmc_power_ctl`

## Requirements
- R1: After reset, `power_en` is 1, `wake_req` is 0, `ctl_rd` reads 0x000000F0, and both `ien_rd` and `stat_rd` read 0.
- R2: In the control register (select 0), only bit 16 and bits 7:0 can be written. All other bits read 0, so writing 0xFFFFFFFF reads back as 0x000100FF.
- R3: While control bit 16 is 0, `power_en` is 1 on the cycle after, even if an enabled alarm pulse arrives.
- R4: With control bit 16 set and interrupt-enable bit 4 set (select 1), an `alarm2_hit` pulse drives `power_en` to 0 on the next cycle and sets status bit 7.
- R5: With interrupt-enable bit 4 clear, an `alarm2_hit` pulse changes neither `power_en` nor `stat_rd`.
- R6: Writing status (select 2) with bit 7 set clears status bit 7. Writing it with bit 7 clear leaves status bit 7 unchanged. If an enabled alarm and a clearing write fall in the same cycle, the flag stays set.
- R7: Control bit n (n = 0..3) enables wake pin n. Control bit 4+n sets that pin's polarity: 1 means active low and 0 means active high. A pin change shows on `wake_req` after the second clock edge and not after the first.
- R8: A pin whose enable bit is 0 never raises `wake_req`, whatever its level or polarity.
- R9: When `wake_req` is 1 while `power_en` is 0, the next edge sets `power_en` to 1 and clears control bit 16.
- R10: When `wake_req` is 1 while `power_en` is 1, the wake request leaves `power_en` and the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 interrupt enable, 2 status |
| wr_data | input | 32 | Write data |
| alarm2_hit | input | 1 | One-cycle pulse on a second-alarm match |
| wake_pins | input | 4 | Asynchronous wakeup pins |
| power_en | output | 1 | Enable line to the external supply, 1 = on |
| wake_req | output | 1 | Wake request from the enabled, active pins |
| ctl_rd | output | 32 | Control register readback |
| ien_rd | output | 8 | Interrupt-enable readback (bit 4) |
| stat_rd | output | 8 | Status readback (bit 7) |

## Verification
The assertions assume that `alarm2_hit` is a single-cycle pulse produced in the clock domain. They also assume that register writes are synchronous and whole-word. The only asynchronous inputs they accept are the wake pins, and those are checked only after the synchronizer. The bench follows these assumptions: it changes inputs only on falling edges, raises the alarm for exactly one cycle, and holds each pin level for at least three edges before it looks at the power state.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int WAKE_N      = 4;
    localparam int REG_W       = 32;
    localparam int BYTE_W      = 8;
    localparam int PWR_BIT     = 16;
    localparam int POL_LSB     = WAKE_N;
    localparam int ALM_IE_BIT  = 4;
    localparam int ALM_ST_BIT  = 7;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic              arm;
        logic [WAKE_N-1:0] pol_low;
        logic [WAKE_N-1:0] wake_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{arm: 1'b0, pol_low: '1, wake_en: '0};

    function automatic logic [REG_W-1:0] ctl_pack(input ctl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[WAKE_N-1:0]              = c.wake_en;
        v[POL_LSB +: WAKE_N]       = c.pol_low;
        v[PWR_BIT]                 = c.arm;
        return v;
    endfunction

    function automatic ctl_t ctl_unpack(input logic [REG_W-1:0] v);
        ctl_t c;
        c.wake_en = v[WAKE_N-1:0];
        c.pol_low = v[POL_LSB +: WAKE_N];
        c.arm     = v[PWR_BIT];
        return c;
    endfunction

endpackage

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins_async,
    output logic [N-1:0] pins_sync
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], pins_async[i]};
            end
            assign pins_sync[i] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             alarm_hit,
    input  logic             wake_clr,
    output ctl_t             ctl,
    output logic             alm_ie,
    output logic             alm_st,
    output logic             alarm_act
);
    ctl_t ctl_q;
    logic ie_q, st_q;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[REG_W-1:PWR_BIT+1], wr_data[PWR_BIT-1:BYTE_W]};
    assign alarm_act = alarm_hit & ie_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
            ie_q  <= 1'b0;
            st_q  <= 1'b0;
        end else begin
            if (wr_en && wr_sel == SEL_CTL) ctl_q <= ctl_unpack(wr_data);
            if (wake_clr)                   ctl_q.arm <= 1'b0;
            if (wr_en && wr_sel == SEL_IEN) ie_q <= wr_data[ALM_IE_BIT];
            if (alarm_act)
                st_q <= 1'b1;
            else if (wr_en && wr_sel == SEL_STAT && wr_data[ALM_ST_BIT])
                st_q <= 1'b0;
        end
    end

    assign ctl    = ctl_q;
    assign alm_ie = ie_q;
    assign alm_st = st_q;

    // R4
    alarm_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_hit && ie_q) |=> st_q);

    // R5
    masked_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm_hit && !ie_q && !(wr_en && wr_sel == SEL_STAT)) |=> $stable(st_q));

    // R9
    wake_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        wake_clr |=> !ctl_q.arm);
endmodule

// File: rtl/pmc_power.sv
module pmc_power (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic alarm_act,
    input  logic wake_req,
    output logic power_en,
    output logic wake_clr
);
    logic on_q;

    assign wake_clr = wake_req & ~on_q;

    always_ff @(posedge clk) begin
        if (rst)                      on_q <= 1'b1;
        else if (!arm || wake_clr)    on_q <= 1'b1;
        else if (alarm_act)           on_q <= 1'b0;
    end

    assign power_en = on_q;

    // R3
    unarmed_on_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> on_q);

    // R4
    alarm_off_chk: assert property (@(posedge clk) disable iff (rst)
        (arm && alarm_act && on_q) |=> !on_q);

    // R9
    wake_on_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && !on_q) |=> on_q);
endmodule

// File: rtl/pmc_power_ctl.sv
module pmc_power_ctl
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              alarm2_hit,
    input  logic [WAKE_N-1:0] wake_pins,
    output logic              power_en,
    output logic              wake_req,
    output logic [REG_W-1:0]  ctl_rd,
    output logic [BYTE_W-1:0] ien_rd,
    output logic [BYTE_W-1:0] stat_rd
);
    ctl_t              ctl;
    logic              alm_ie, alm_st, alarm_act, wake_clr;
    logic [WAKE_N-1:0] pins_sync, pin_active;

    pmc_wake_sync #(.N(WAKE_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pins_async (wake_pins),
        .pins_sync  (pins_sync)
    );

    pmc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (reg_sel_e'(wr_sel)),
        .wr_data   (wr_data),
        .alarm_hit (alarm2_hit),
        .wake_clr  (wake_clr),
        .ctl       (ctl),
        .alm_ie    (alm_ie),
        .alm_st    (alm_st),
        .alarm_act (alarm_act)
    );

    assign pin_active = (pins_sync ^ ctl.pol_low) & ctl.wake_en;
    assign wake_req   = |pin_active;

    pmc_power u_power (
        .clk       (clk),
        .rst       (rst),
        .arm       (ctl.arm),
        .alarm_act (alarm_act),
        .wake_req  (wake_req),
        .power_en  (power_en),
        .wake_clr  (wake_clr)
    );

    always_comb begin
        ctl_rd  = ctl_pack(ctl);
        ien_rd  = '0;
        ien_rd[ALM_IE_BIT] = alm_ie;
        stat_rd = '0;
        stat_rd[ALM_ST_BIT] = alm_st;
    end

    // R8
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (ctl.wake_en != '0));

    // R10
    wake_while_on_chk: assert property (@(posedge clk) disable iff (rst)
        (wake_req && power_en && ctl.arm && !alarm_act && !wr_en) |=> (power_en && ctl.arm));
endmodule

// File: tb/test_pmc_power_ctl.sv
module test_pmc_power_ctl;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic        alarm2_hit = 1'b0;
    logic [3:0]  wake_pins = 4'hF;
    logic        power_en, wake_req;
    logic [31:0] ctl_rd;
    logic [7:0]  ien_rd, stat_rd;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    pmc_power_ctl i_pmc_power_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .alarm2_hit(alarm2_hit), .wake_pins(wake_pins), .power_en(power_en),
        .wake_req(wake_req), .ctl_rd(ctl_rd), .ien_rd(ien_rd), .stat_rd(stat_rd)
    );

    // {ctl low byte, pins, expected wake_req}
    localparam logic [12:0] VEC [9] = '{
        {8'hF1, 4'b1110, 1'b1},
        {8'hF1, 4'b1111, 1'b0},
        {8'h01, 4'b0001, 1'b1},
        {8'h01, 4'b1110, 1'b0},
        {8'hF0, 4'b0000, 1'b0},
        {8'h08, 4'b1000, 1'b1},
        {8'h88, 4'b0111, 1'b1},
        {8'h84, 4'b1011, 1'b0},
        {8'h0E, 4'b0001, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic alarm_pulse();
        alarm2_hit = 1'b1;
        tick(1);
        alarm2_hit = 1'b0;
    endtask

    initial begin
        #400000;
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 power_en", {31'd0, power_en}, 32'd1);
        chk("R1 wake_req", {31'd0, wake_req}, 32'd0);
        chk("R1 ctl", ctl_rd, 32'h0000_00F0);
        chk("R1 ien", {24'd0, ien_rd}, 32'd0);
        chk("R1 stat", {24'd0, stat_rd}, 32'd0);

        // R2 writable mask
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R2 ctl mask", ctl_rd, 32'h0001_00FF);
        wr(2'd0, 32'h0000_0000);
        chk("R2 ctl zero", ctl_rd, 32'h0);

        // R7 / R8 decode table
        for (int k = 0; k < 9; k++) begin
            wr(2'd0, {24'd0, VEC[k][12:5]});
            wake_pins = VEC[k][4:1];
            tick(3);
            chk($sformatf("R7/R8 vec%0d wake_req", k), {31'd0, wake_req}, {31'd0, VEC[k][0]});
            chk($sformatf("R3 vec%0d power_en", k), {31'd0, power_en}, 32'd1);
        end
        wake_pins = 4'hF;
        tick(3);

        // R5 masked alarm
        wr(2'd1, 32'h0);
        wr(2'd0, 32'h0001_00F0);
        alarm_pulse();
        chk("R5 power_en", {31'd0, power_en}, 32'd1);
        chk("R5 stat", {24'd0, stat_rd}, 32'd0);

        // R3 unarmed alarm
        wr(2'd1, 32'h10);
        chk("R4 ien readback", {24'd0, ien_rd}, 32'h10);
        wr(2'd0, 32'h0000_00F0);
        alarm_pulse();
        chk("R3 power_en unarmed", {31'd0, power_en}, 32'd1);
        wr(2'd2, 32'h80);

        // R4 armed alarm
        wr(2'd0, 32'h0001_00F1);
        alarm_pulse();
        chk("R4 power_en off", {31'd0, power_en}, 32'd0);
        chk("R4 stat", {24'd0, stat_rd}, 32'h80);

        // R6 write 0 keeps, set wins, write 1 clears
        wr(2'd2, 32'h7F);
        chk("R6 write0 keeps", {24'd0, stat_rd}, 32'h80);
        alarm2_hit = 1'b1;
        wr(2'd2, 32'h80);
        alarm2_hit = 1'b0;
        chk("R6 set wins", {24'd0, stat_rd}, 32'h80);
        wr(2'd2, 32'h80);
        chk("R6 clear", {24'd0, stat_rd}, 32'h0);

        // R9 + R7 latency: pin0 active low while off
        wake_pins = 4'b1110;
        tick(1);
        chk("R7 one edge no wake", {31'd0, wake_req}, 32'd0);
        tick(1);
        chk("R7 two edges wake", {31'd0, wake_req}, 32'd1);
        chk("R9 still off", {31'd0, power_en}, 32'd0);
        tick(1);
        chk("R9 power back on", {31'd0, power_en}, 32'd1);
        chk("R9 arm cleared", ctl_rd, 32'h0000_00F1);
        wake_pins = 4'hF;
        tick(3);

        // R10 wake while on
        wr(2'd0, 32'h0001_0011);
        wake_pins = 4'b1110;
        tick(4);
        chk("R10 wake_req", {31'd0, wake_req}, 32'd1);
        chk("R10 power_en", {31'd0, power_en}, 32'd1);
        chk("R10 ctl", ctl_rd, 32'h0001_0011);
        wake_pins = 4'hF;
        tick(3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule